// File: doc/BRIEF.md
# Shared-Counter PWM Timer

This block is a register-mapped timer that drives one edge-aligned PWM output per channel. All channels share one up-counter, one prescaler and one period limit, so every channel runs at the same frequency. Each channel sets its own pulse width and output sense. The counter steps once every 2^PS clock cycles and runs from zero up to the period limit. On the next step it returns to zero, and that step starts a new period for all channels together.

Software reaches the block through a single-cycle register port. A write is taken on the clock edge where the write enable is high, and the read data is a combinational function of the address. While the counter is stopped, new period-limit and compare values take effect at once. While it runs, each new value is parked and loaded when the next period begins, so a period is never cut short or stretched by a write. A read always returns the value in use, so software can poll until its write has landed. The output select of a channel is not buffered: a change to it reaches the pin on the edge that writes it.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset the counter, period limit, status/control, every channel control and every compare value read zero, and every PWM output is low.
- R2: Address 0x04 reads the number of channels (parameter NUM_CH) in bits [7:0]. Writes to it have no effect.
- R3: Status/control is at 0x10. Bits [2:0] hold the prescaler code PS and bits [4:3] hold the run mode. With mode 01 the counter advances once every 2^PS clocks. With any other mode it holds its value. Bit 5 always reads 0.
- R4: A running counter counts 0, 1, ... up to the period limit (0x18, 16 bits) and then returns to 0. One period therefore lasts (limit+1)·2^PS clocks.
- R5: A write of any value to the counter address 0x14 clears both the counter and the prescaler to zero.
- R6: While the counter is stopped, a write to the period limit, or to a channel compare value (0x24+8·n), takes effect on the writing edge. A read of that address then returns the written value.
- R7: While the counter runs, a written period limit or compare value does not take effect until the counter next returns to 0. Until then, reads return the previous value.
- R8: Bits [3:2] of the channel control register (0x20+8·n) select the output. 10 drives high while counter < compare. 01 drives the inverse of that. 00 and 11 drive low.
- R9: With select 10, a compare value of 0 keeps the output low for the whole period, and a compare value above the period limit keeps it high for the whole period.
- R10: A new output select reaches the pin on the clock edge that writes it, even while the counter is in the middle of a period.
- R11: Channel control bit 7 is an event flag. It is set when the counter advances while holding the channel's compare value, and writing 1 to bit 7 clears it. Bits 5 and 4 are stored and read back. Bits 6, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe, captured on the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
Some properties are checked by assertions on every cycle. A stopped counter holds still, a period-end step or a counter write leaves the count at zero, and the active limit and compare values stay fixed between period boundaries while the counter runs. A select write that turns a channel off forces the pin low on the next cycle, and the outputs come out of reset low. The bench scenarios cover what a single cycle cannot show: the high time and period length of each output across prescaler settings and select codes, whether a buffered value lands at the wrap, the event flag, and the read-only channel-count field.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam int OFS_PARAM   = 'h04;
    localparam int OFS_GLOBAL  = 'h08;
    localparam int OFS_SC      = 'h10;
    localparam int OFS_CNT     = 'h14;
    localparam int OFS_MOD     = 'h18;
    localparam int OFS_CH_BASE = 'h20;
    localparam int CH_STRIDE   = 8;
    localparam int CH_CMP_OFS  = 4;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_INV  = 2'b01,
        SEL_NORM = 2'b10,
        SEL_RSVD = 2'b11
    } out_sel_e;

    typedef enum logic [1:0] {
        RUN_STOP = 2'b00,
        RUN_PCLK = 2'b01,
        RUN_RSV2 = 2'b10,
        RUN_RSV3 = 2'b11
    } run_mode_e;

    typedef struct packed {
        logic     flag;
        logic     mode_b;
        logic     mode_a;
        out_sel_e sel;
    } ch_ctrl_t;

    function automatic int ctrl_addr(input int n);
        return OFS_CH_BASE + CH_STRIDE * n;
    endfunction

    function automatic int cmp_addr(input int n);
        return OFS_CH_BASE + CH_STRIDE * n + CH_CMP_OFS;
    endfunction

    // Output level for a select code given whether the count is below compare.
    function automatic logic drive_level(input out_sel_e sel, input logic below);
        case (sel)
            SEL_NORM: return below;
            SEL_INV:  return ~below;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] pack_ctrl(input ch_ctrl_t c);
        return {c.flag, 1'b0, c.mode_b, c.mode_a, c.sel, 2'b00};
    endfunction

endpackage

// File: rtl/pwmt_timebase.sv
module pwmt_timebase
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [PS_W-1:0]  ps_i,
    input  logic             cnt_clr_i,
    input  logic             mod_we_i,
    input  logic [CNT_W-1:0] mod_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mod_o,
    output logic             tick_o,
    output logic             wrap_o
);

    localparam int PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_act_q;
    logic [CNT_W-1:0] mod_buf_q;

    // Terminal prescaler value is 2^PS - 1: a run of PS low ones.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            pre_lim[i] = (i < int'(ps_i));
        end
    end

    // >= keeps the divider safe if PS is lowered mid-count.
    assign tick_o = run_i && (pre_q >= pre_lim);
    // >= also recovers when the limit was lowered below the count while stopped.
    assign wrap_o = tick_o && (cnt_q >= mod_act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q     <= '0;
            cnt_q     <= '0;
            mod_act_q <= '0;
            mod_buf_q <= '0;
        end else begin
            if (cnt_clr_i) begin
                pre_q <= '0;
                cnt_q <= '0;
            end else if (tick_o) begin
                pre_q <= '0;
                cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
            end else if (run_i) begin
                pre_q <= pre_q + PRE_W'(1);
            end

            if (mod_we_i) begin
                mod_buf_q <= mod_wdata_i;
            end
            if (mod_we_i && !run_i) begin
                mod_act_q <= mod_wdata_i;
            end else if (wrap_o) begin
                mod_act_q <= mod_we_i ? mod_wdata_i : mod_buf_q;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign mod_o = mod_act_q;

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !cnt_clr_i) |=> $stable(cnt_q));
    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_q == '0));
    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_i |=> (cnt_q == '0 && pre_q == '0));
    // R6
    mod_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_we_i && !run_i) |=> (mod_act_q == $past(mod_wdata_i)));
    // R7
    mod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !wrap_o) |=> $stable(mod_act_q));

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ctrl_we_i,
    input  logic [7:0]       ctrl_wdata_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    output ch_ctrl_t         ctrl_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             pwm_o
);

    ch_ctrl_t         ctrl_q;
    logic [CNT_W-1:0] cmp_act_q;
    logic [CNT_W-1:0] cmp_buf_q;
    logic             hit;
    logic             flag_clr;
    logic             unused_ctrl_bits;

    assign unused_ctrl_bits = ^{ctrl_wdata_i[6], ctrl_wdata_i[1:0]};
    assign hit      = tick_i && (cnt_i == cmp_act_q);
    assign flag_clr = ctrl_we_i && ctrl_wdata_i[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            cmp_act_q <= '0;
            cmp_buf_q <= '0;
        end else begin
            if (ctrl_we_i) begin
                ctrl_q.sel    <= out_sel_e'(ctrl_wdata_i[3:2]);
                ctrl_q.mode_a <= ctrl_wdata_i[4];
                ctrl_q.mode_b <= ctrl_wdata_i[5];
            end
            if (hit) begin
                ctrl_q.flag <= 1'b1;
            end else if (flag_clr) begin
                ctrl_q.flag <= 1'b0;
            end

            if (cmp_we_i) begin
                cmp_buf_q <= cmp_wdata_i;
            end
            if (cmp_we_i && !run_i) begin
                cmp_act_q <= cmp_wdata_i;
            end else if (wrap_i) begin
                cmp_act_q <= cmp_we_i ? cmp_wdata_i : cmp_buf_q;
            end
        end
    end

    // Output decoded straight from flops: select acts on the writing edge.
    assign pwm_o  = drive_level(ctrl_q.sel, cnt_i < cmp_act_q);
    assign ctrl_o = ctrl_q;
    assign cmp_o  = cmp_act_q;

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !wrap_i) |=> $stable(cmp_act_q));
    // R10
    sel_off_now_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we_i && (ctrl_wdata_i[3:2] == 2'b00 || ctrl_wdata_i[3:2] == 2'b11))
        |=> !pwm_o);
    // R11
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> ctrl_q.flag);

endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
    import pwmt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    output logic [NUM_CH-1:0] pwm_o
);

    localparam int DATA_W = 32;

    logic [PS_W-1:0]  ps_q;
    run_mode_e        mode_q;
    logic             run;
    logic             sc_we;
    logic             cnt_we;
    logic             mod_we;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mod_act;
    logic             tick;
    logic             wrap;
    logic             unused_wdata;

    ch_ctrl_t         ch_ctrl [NUM_CH];
    logic [CNT_W-1:0] ch_cmp  [NUM_CH];

    assign unused_wdata = ^wr_data_i[DATA_W-1:CNT_W];

    assign sc_we  = wr_en_i && (addr_i == ADDR_W'(OFS_SC));
    assign cnt_we = wr_en_i && (addr_i == ADDR_W'(OFS_CNT));
    assign mod_we = wr_en_i && (addr_i == ADDR_W'(OFS_MOD));
    assign run    = (mode_q == RUN_PCLK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q   <= '0;
            mode_q <= RUN_STOP;
        end else if (sc_we) begin
            ps_q   <= wr_data_i[PS_W-1:0];
            mode_q <= run_mode_e'(wr_data_i[4:3]);
        end
    end

    pwmt_timebase #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W)
    ) u_timebase (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run),
        .ps_i        (ps_q),
        .cnt_clr_i   (cnt_we),
        .mod_we_i    (mod_we),
        .mod_wdata_i (wr_data_i[CNT_W-1:0]),
        .cnt_o       (cnt),
        .mod_o       (mod_act),
        .tick_o      (tick),
        .wrap_o      (wrap)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic ctrl_we;
        logic cmp_we;

        assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(ctrl_addr(n)));
        assign cmp_we  = wr_en_i && (addr_i == ADDR_W'(cmp_addr(n)));

        pwmt_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk          (clk),
            .rst          (rst),
            .run_i        (run),
            .tick_i       (tick),
            .wrap_i       (wrap),
            .cnt_i        (cnt),
            .ctrl_we_i    (ctrl_we),
            .ctrl_wdata_i (wr_data_i[7:0]),
            .cmp_we_i     (cmp_we),
            .cmp_wdata_i  (wr_data_i[CNT_W-1:0]),
            .ctrl_o       (ch_ctrl[n]),
            .cmp_o        (ch_cmp[n]),
            .pwm_o        (pwm_o[n])
        );
    end

    always_comb begin
        rd_data_o = '0;
        if (addr_i == ADDR_W'(OFS_PARAM)) begin
            rd_data_o[7:0] = 8'(NUM_CH);
        end else if (addr_i == ADDR_W'(OFS_SC)) begin
            rd_data_o[PS_W-1:0] = ps_q;
            rd_data_o[4:3]      = mode_q;
        end else if (addr_i == ADDR_W'(OFS_CNT)) begin
            rd_data_o[CNT_W-1:0] = cnt;
        end else if (addr_i == ADDR_W'(OFS_MOD)) begin
            rd_data_o[CNT_W-1:0] = mod_act;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr_i == ADDR_W'(ctrl_addr(n))) begin
                rd_data_o[7:0] = pack_ctrl(ch_ctrl[n]);
            end
            if (addr_i == ADDR_W'(cmp_addr(n))) begin
                rd_data_o[CNT_W-1:0] = ch_cmp[n];
            end
        end
    end

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (pwm_o == '0));

endmodule

// File: tb/pwm_shared_timer_tb_top.sv
module pwm_shared_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int A_PARAM = 'h04, A_SC = 'h10, A_CNT = 'h14, A_MOD = 'h18;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     addr = '0;
    logic           wr_en = 1'b0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] pwm;

    int checks = 0;
    int errors = 0;

    int cfg_m;
    int cfg_ps;
    int cfg_cv  [NCH];
    int cfg_sel [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_shared_timer #(.NUM_CH(NCH), .CNT_W(16), .PS_W(3), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wdata),
        .rd_data_o (rd_data),
        .pwm_o     (pwm)
    );

    function automatic int a_ctrl(input int n); return 'h20 + 8*n; endfunction
    function automatic int a_cmp(input int n);  return 'h24 + 8*n; endfunction

    // High clocks per period, from R8/R9.
    function automatic int exp_high(input int sel, input int cv, input int m, input int ps);
        int on;
        int per;
        per = (m + 1) << ps;
        on  = ((cv > m) ? (m + 1) : cv) << ps;
        if (sel == 2) return on;
        if (sel == 1) return per - on;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr  = 8'(a);
        wdata = 32'(d);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = 8'(a);
        #1;
        d = int'(rd_data);
    endtask

    task automatic configure();
        wr(A_SC, 0);
        wr(A_CNT, 0);
        wr(A_MOD, cfg_m);
        for (int c = 0; c < NCH; c++) begin
            wr(a_cmp(c), cfg_cv[c]);
            wr(a_ctrl(c), 'h80 | 'h20 | (cfg_sel[c] << 2));
        end
        wr(A_SC, (1 << 3) | cfg_ps);
    endtask

    task automatic measure_period(input int ch, output int len);
        logic prev;
        int   t;
        len = -1;
        prev = 1'b1;
        t = 0;
        while (t < 2000) begin
            @(negedge clk);
            t++;
            if (!prev && pwm[ch]) break;
            prev = pwm[ch];
        end
        len = 0;
        prev = 1'b1;
        while (len < 2000) begin
            @(negedge clk);
            len++;
            if (!prev && pwm[ch]) break;
            prev = pwm[ch];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v;
        int v2;
        int seed;
        int hi [NCH];
        int win;
        int plen;
        string tag;

        seed = int'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pwm", int'(pwm), 0);
        rd(A_CNT, v);      check("R1 cnt", v, 0);
        rd(A_MOD, v);      check("R1 mod", v, 0);
        rd(A_SC, v);       check("R1 sc", v, 0);
        rd(a_ctrl(0), v);  check("R1 ctrl0", v, 0);
        rd(a_cmp(3), v);   check("R1 cmp3", v, 0);

        // R2 channel count, read-only
        rd(A_PARAM, v);    check("R2 param", v, NCH);
        wr(A_PARAM, 'hFF);
        rd(A_PARAM, v);    check("R2 param after write", v, NCH);

        // R3 bit 5 reads zero, fields read back
        wr(A_SC, 'h3F);
        rd(A_SC, v);       check("R3 sc readback", v, 'h1F);
        wr(A_SC, 0);

        // R3 stopped counter holds; R5 counter clear
        wr(A_MOD, 1000);
        wr(A_SC, 'h08);
        repeat (20) @(negedge clk);
        wr(A_SC, 0);
        rd(A_CNT, v);
        check("R3 counter advanced", int'(v > 0), 1);
        repeat (10) @(negedge clk);
        rd(A_CNT, v2);     check("R3 stopped hold", v2, v);
        wr(A_CNT, 'h1234);
        rd(A_CNT, v);      check("R5 cnt clear", v, 0);

        // R6 immediate while stopped
        wr(A_MOD, 7);
        rd(A_MOD, v);      check("R6 mod direct", v, 7);
        wr(a_cmp(1), 3);
        rd(a_cmp(1), v);   check("R6 cmp direct", v, 3);

        // R4 period length for two prescaler settings
        cfg_m = 9; cfg_ps = 1;
        for (int c = 0; c < NCH; c++) begin cfg_cv[c] = 1; cfg_sel[c] = 2; end
        configure();
        measure_period(0, plen);
        check("R4 period m9 ps1", plen, 20);
        cfg_m = 5; cfg_ps = 2;
        configure();
        measure_period(2, plen);
        check("R4 period m5 ps2", plen, 24);

        // R8 R9 R11: directed first pass, then random passes
        for (int it = 0; it < 14; it++) begin
            if (it == 0) begin
                cfg_m = 10; cfg_ps = 0;
                cfg_cv[0] = 0;  cfg_sel[0] = 2;
                cfg_cv[1] = 11; cfg_sel[1] = 2;
                cfg_cv[2] = 0;  cfg_sel[2] = 1;
                cfg_cv[3] = 5;  cfg_sel[3] = 3;
            end else begin
                cfg_m  = 2 + int'($urandom % 30);
                cfg_ps = int'($urandom % 3);
                for (int c = 0; c < NCH; c++) begin
                    cfg_cv[c]  = int'($urandom % (cfg_m + 4));
                    cfg_sel[c] = int'($urandom % 4);
                end
            end
            configure();
            repeat (4) @(negedge clk);
            for (int c = 0; c < NCH; c++) hi[c] = 0;
            win = 2 * ((cfg_m + 1) << cfg_ps);
            for (int k = 0; k < win; k++) begin
                @(negedge clk);
                for (int c = 0; c < NCH; c++) hi[c] += int'(pwm[c]);
            end
            for (int c = 0; c < NCH; c++) begin
                tag = (cfg_cv[c] == 0 || cfg_cv[c] > cfg_m) ? "R9 high time" : "R8 high time";
                check(tag, hi[c], 2 * exp_high(cfg_sel[c], cfg_cv[c], cfg_m, cfg_ps));
                rd(a_ctrl(c), v);
                check("R11 ctrl flag/readback", v,
                      ((cfg_cv[c] <= cfg_m) ? 'h80 : 0) | 'h20 | (cfg_sel[c] << 2));
            end
        end

        // R11 flag clear by writing 1
        wr(A_SC, 0);
        wr(a_ctrl(0), 'h80 | 'h10 | (2 << 2));
        rd(a_ctrl(0), v);  check("R11 flag clear", v, 'h10 | (2 << 2));

        // R7 buffered while running
        cfg_m = 30; cfg_ps = 0;
        for (int c = 0; c < NCH; c++) begin cfg_cv[c] = 5; cfg_sel[c] = 2; end
        configure();
        v = -1;
        for (int k = 0; k < 200 && v != 10; k++) rd(A_CNT, v);
        wr(a_cmp(0), 12);
        wr(A_MOD, 20);
        rd(a_cmp(0), v);   check("R7 cmp pending", v, 5);
        rd(A_MOD, v);      check("R7 mod pending", v, 30);
        repeat (40) @(negedge clk);
        rd(a_cmp(0), v);   check("R7 cmp landed", v, 12);
        rd(A_MOD, v);      check("R7 mod landed", v, 20);

        // R10 select acts on the writing edge
        wr(a_ctrl(0), 0);
        check("R10 off immediate", int'(pwm[0]), 0);
        wr(a_cmp(0), 25);
        repeat (30) @(negedge clk);
        wr(a_ctrl(0), 2 << 2);
        check("R10 normal immediate (cmp>mod)", int'(pwm[0]), 1);
        wr(a_ctrl(0), 1 << 2);
        check("R10 inverted immediate", int'(pwm[0]), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule